// File: doc/BRIEF.md
# Diode Bridge Rectifier Load Model

This block is a fixed-step, real-time model of a single-phase diode bridge that feeds a smoothing capacitor with a resistive load across it. Each time the step strobe fires, it reads the instantaneous supply voltage. It then advances two states, the line current and the DC-link voltage, by one forward-Euler step. The new line current serves as the current reference for a power converter that is emulating the rectifier.

Every step picks one of three conduction modes: the forward diode pair, the reverse diode pair, or all diodes blocking. The choice uses the supply voltage together with the states as they stood before the step. Each mode applies its own state-space matrices. In the blocking mode the line current is forced to zero, while the capacitor keeps discharging into the load.

The states are 32-bit signed values in Q16.16 (volts, amperes). The step-scaled circuit coefficients are integer parameters scaled by 2^FRAC. With the defaults (FRAC = 24, step 20 us, R = 0.1 ohm, L = 100 uH, C = 1000 uF, load 100 ohm) they are KL = dt/L, KR = dt·R/L, KC = dt/C and KD = dt/(Rload·C).

Top module: `diode_load_model`

## Requirements
- R1: While `rst` is high at a clock edge, `i_out` and `vdc_out` become 0, `mode_out` becomes 0 and `valid_out` becomes 0.
- R2: The states change only at an edge where `step` is high. `valid_out` is high in exactly the cycle after each such edge. With `step` low, `i_out` and `vdc_out` hold their values.
- R3: Mode code 1 (forward pair) is used when `vs_in > vdc` or `i > 0`, with both compared as signed values on the pre-step state.
- R4: Mode code 2 (reverse pair) is used when `-vs_in > vdc` or `i < 0`, and the forward condition is false. When both conditions hold, the forward mode wins. Code 3 never appears.
- R5: Mode code 0 (blocking) is used when neither condition holds. The new current is then exactly 0.
- R6: In mode 1 the new current is `i + ((KL*(vs-vdc) - KR*i) >>> FRAC)` and the new DC voltage is `vdc + ((KC*i - KD*vdc) >>> FRAC)`, computed with full-width products and an arithmetic (floor) shift.
- R7: In mode 2 the new current is `i + ((KL*(vs+vdc) - KR*i) >>> FRAC)` and the new DC voltage is `vdc + ((-KC*i - KD*vdc) >>> FRAC)`.
- R8: In mode 0 the new DC voltage is `vdc + ((-KD*vdc) >>> FRAC)`, so a positive DC voltage decays toward zero.
- R9: A new state value outside the 32-bit signed range is clipped to 0x7FFFFFFF or 0x80000000.
- R10: `mode_out` reports the mode used by the most recent step. The mode is decided on the state held before that step, not on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One-cycle strobe that triggers one Euler step |
| vs_in | input | 32 | Supply voltage sample, signed Q16.16 volts |
| i_out | output | 32 | Line current state, signed Q16.16 amperes |
| vdc_out | output | 32 | DC-link voltage state, signed Q16.16 volts |
| mode_out | output | 2 | Conduction mode of the last step (0 blocking, 1 forward, 2 reverse) |
| valid_out | output | 1 | High for one cycle when new states are presented |

## Verification
The bench drives a positive current against a strongly negative supply. A design that tested the reverse condition first, or that decided the mode on the freshly computed current, would report mode 2 at that point and take the wrong slope. It also solves for a supply sample that brings the current exactly back to zero with a charged capacitor, and then applies zero volts. A design that froze the capacitor in the blocking mode, or that left a residual current there, shows a DC voltage that fails to decay. A run at full-scale supply pushes the current past the 32-bit range: a wrapping adder would flip the current negative instead of pinning it at the maximum. Idle gaps between strobes expose any update that happens without a strobe.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_FWD = 2'd1,
    MODE_REV = 2'd2
  } cond_mode_e;

endpackage

// File: rtl/dlm_mode_sel.sv
module dlm_mode_sel
  import dlm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic signed [W-1:0] vs,
  input  logic signed [W-1:0] vdc,
  input  logic signed [W-1:0] cur,
  output cond_mode_e          mode
);

  logic signed [W:0] vs_x;
  logic signed [W:0] vdc_x;
  logic signed [W:0] vs_neg;
  logic              fwd_on;
  logic              rev_on;

  always_comb begin
    vs_x   = (W+1)'(vs);
    vdc_x  = (W+1)'(vdc);
    vs_neg = -vs_x;
    fwd_on = (vs_x > vdc_x) || (cur > 0);
    rev_on = (vs_neg > vdc_x) || (cur < 0);
    // forward pair takes priority when both conditions hold
    if (fwd_on)      mode = MODE_FWD;
    else if (rev_on) mode = MODE_REV;
    else             mode = MODE_OFF;
  end

endmodule

// File: rtl/dlm_sat.sv
module dlm_sat #(
  parameter int IN_W  = 68,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0]  d,
  output logic signed [OUT_W-1:0] q
);

  localparam logic signed [IN_W-1:0] HI = IN_W'({1'b0, {(OUT_W-1){1'b1}}});
  localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

  always_comb begin
    if (d > HI)      q = HI[OUT_W-1:0];
    else if (d < LO) q = LO[OUT_W-1:0];
    else             q = d[OUT_W-1:0];
  end

endmodule

// File: rtl/dlm_euler_step.sv
module dlm_euler_step
  import dlm_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 24,
  parameter int KL   = 3355443,
  parameter int KR   = 335544,
  parameter int KC   = 335544,
  parameter int KD   = 3355
) (
  input  cond_mode_e          mode,
  input  logic signed [W-1:0] vs,
  input  logic signed [W-1:0] cur,
  input  logic signed [W-1:0] vdc,
  output logic signed [W-1:0] cur_nx,
  output logic signed [W-1:0] vdc_nx
);

  localparam int ACC_W = 2 * W + 4;
  localparam logic signed [ACC_W-1:0] CL = ACC_W'(KL);
  localparam logic signed [ACC_W-1:0] CR = ACC_W'(KR);
  localparam logic signed [ACC_W-1:0] CC = ACC_W'(KC);
  localparam logic signed [ACC_W-1:0] CD = ACC_W'(KD);

  logic signed [ACC_W-1:0] vs_e, cur_e, vdc_e;
  logic signed [ACC_W-1:0] drive, cap_in;
  logic signed [ACC_W-1:0] cur_acc, vdc_acc;
  logic signed [ACC_W-1:0] cur_sum, vdc_sum;

  always_comb begin
    vs_e  = ACC_W'(vs);
    cur_e = ACC_W'(cur);
    vdc_e = ACC_W'(vdc);
    case (mode)
      MODE_FWD: begin
        drive  = vs_e - vdc_e;
        cap_in = cur_e;
      end
      MODE_REV: begin
        drive  = vs_e + vdc_e;
        cap_in = -cur_e;
      end
      default: begin
        drive  = '0;
        cap_in = '0;
      end
    endcase
    cur_acc = CL * drive - CR * cur_e;
    vdc_acc = CC * cap_in - CD * vdc_e;
    vdc_sum = vdc_e + (vdc_acc >>> FRAC);
    if (mode == MODE_OFF) cur_sum = '0;
    else                  cur_sum = cur_e + (cur_acc >>> FRAC);
  end

  dlm_sat #(.IN_W(ACC_W), .OUT_W(W)) u_sat_cur (.d(cur_sum), .q(cur_nx));
  dlm_sat #(.IN_W(ACC_W), .OUT_W(W)) u_sat_vdc (.d(vdc_sum), .q(vdc_nx));

endmodule

// File: rtl/diode_load_model.sv
module diode_load_model
  import dlm_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int FRAC    = 24,
  parameter int KL      = 3355443,
  parameter int KR      = 335544,
  parameter int KC      = 335544,
  parameter int KD      = 3355
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic signed [STATE_W-1:0] vs_in,
  output logic signed [STATE_W-1:0] i_out,
  output logic signed [STATE_W-1:0] vdc_out,
  output logic [1:0]                mode_out,
  output logic                      valid_out
);

  logic signed [STATE_W-1:0] cur_q, vdc_q;
  logic signed [STATE_W-1:0] cur_nx, vdc_nx;
  cond_mode_e                mode_sel, mode_q;
  logic                      valid_q;

  dlm_mode_sel #(.W(STATE_W)) u_mode (
    .vs   (vs_in),
    .vdc  (vdc_q),
    .cur  (cur_q),
    .mode (mode_sel)
  );

  dlm_euler_step #(
    .W(STATE_W), .FRAC(FRAC), .KL(KL), .KR(KR), .KC(KC), .KD(KD)
  ) u_step (
    .mode   (mode_sel),
    .vs     (vs_in),
    .cur    (cur_q),
    .vdc    (vdc_q),
    .cur_nx (cur_nx),
    .vdc_nx (vdc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      vdc_q   <= '0;
      mode_q  <= MODE_OFF;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step;
      if (step) begin
        cur_q  <= cur_nx;
        vdc_q  <= vdc_nx;
        mode_q <= mode_sel;
      end
    end
  end

  assign i_out     = cur_q;
  assign vdc_out   = vdc_q;
  assign mode_out  = mode_q;
  assign valid_out = valid_q;

endmodule

// File: rtl/diode_load_model_chk.sv
module diode_load_model_chk #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                step,
  input logic signed [W-1:0] vs_in,
  input logic signed [W-1:0] i_out,
  input logic signed [W-1:0] vdc_out,
  input logic [1:0]          mode_out,
  input logic                valid_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (i_out == '0 && vdc_out == '0 && mode_out == 2'd0 && !valid_out));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> valid_out);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> !valid_out);

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(i_out) && $stable(vdc_out)));

  // R4
  legal_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_out != 2'd3);

  // R5
  off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_out && mode_out == 2'd0) |-> (i_out == '0));

  // R3
  fwd_on_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (step && i_out > 0) |=> (mode_out == 2'd1));

  // R10
  rev_on_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (step && i_out < 0 && !(vs_in > vdc_out)) |=> (mode_out == 2'd2));

endmodule

bind diode_load_model diode_load_model_chk #(.W(STATE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .vs_in     (vs_in),
  .i_out     (i_out),
  .vdc_out   (vdc_out),
  .mode_out  (mode_out),
  .valid_out (valid_out)
);

// File: tb/diode_load_model_tb.sv
module diode_load_model_tb;

  localparam int W    = 32;
  localparam int FRAC = 24;
  localparam int KL   = 3355443;
  localparam int KR   = 335544;
  localparam int KC   = 335544;
  localparam int KD   = 3355;
  localparam logic signed [W-1:0] SMAX = 32'sh7FFFFFFF;

  typedef struct packed {
    logic signed [W-1:0] cur;
    logic signed [W-1:0] vdc;
    logic [1:0]          mode;
  } exp_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                step = 1'b0;
  logic signed [W-1:0] vs_in = '0;
  logic signed [W-1:0] i_out, vdc_out;
  logic [1:0]          mode_out;
  logic                valid_out;

  int checks = 0;
  int fails  = 0;
  logic signed [W-1:0] m_cur = '0;
  logic signed [W-1:0] m_vdc = '0;
  logic                sat_seen = 1'b0;
  exp_t                sb_q[$];

  always #4 clk = ~clk;

  diode_load_model #(
    .STATE_W(W), .FRAC(FRAC), .KL(KL), .KR(KR), .KC(KC), .KD(KD)
  ) u_dut (
    .clk(clk), .rst(rst), .step(step), .vs_in(vs_in),
    .i_out(i_out), .vdc_out(vdc_out), .mode_out(mode_out), .valid_out(valid_out)
  );

  function automatic logic signed [W-1:0] clip(input logic signed [95:0] x, ref logic hit);
    if (x > 96'sh7FFFFFFF)        begin hit = 1'b1; return 32'sh7FFFFFFF; end
    if (x < -96'sh80000000)       begin hit = 1'b1; return 32'sh80000000; end
    return x[W-1:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3 R4 R5 R6 R7 R8 R9 R10: reference step on the bench's own state
  task automatic drive_step(input logic signed [W-1:0] vs);
    logic signed [95:0] v, i, d, s, ai, av, ni, nv;
    exp_t e;
    v = 96'(vs); i = 96'(m_cur); d = 96'(m_vdc);
    if (v > d || i > 0) begin
      e.mode = 2'd1;
      ai = 96'(KL) * (v - d) - 96'(KR) * i;
      av = 96'(KC) * i - 96'(KD) * d;
      ni = i + (ai >>> FRAC);
    end else if (-v > d || i < 0) begin
      e.mode = 2'd2;
      ai = 96'(KL) * (v + d) - 96'(KR) * i;
      av = -(96'(KC) * i) - 96'(KD) * d;
      ni = i + (ai >>> FRAC);
    end else begin
      e.mode = 2'd0;
      av = -(96'(KD) * d);
      ni = '0;
    end
    nv = d + (av >>> FRAC);
    s = ni;
    m_cur = clip(s, sat_seen);
    m_vdc = clip(nv, sat_seen);
    e.cur = m_cur;
    e.vdc = m_vdc;
    @(negedge clk);
    vs_in = vs;
    step  = 1'b1;
    sb_q.push_back(e);
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cur = '0;
    m_vdc = '0;
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (valid_out) begin
        if (sb_q.size() == 0) begin
          check("R2 unexpected valid", 64'(valid_out), 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check("R3/R4/R5/R10 mode", 64'(mode_out), 64'(e.mode));
          check("R5/R6/R7/R9 current", 64'(i_out), 64'(e.cur));
          check("R6/R7/R8/R9 dc voltage", 64'(vdc_out), 64'(e.vdc));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic signed [95:0] x;
    logic signed [W-1:0] v_before, hold_i, hold_v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 current", 64'(i_out), 64'd0);
    check("R1 dc voltage", 64'(vdc_out), 64'd0);
    check("R1 mode", 64'(mode_out), 64'd0);
    check("R1 valid", 64'(valid_out), 64'd0);
    rst = 1'b0;

    // R5: zero supply on an empty circuit blocks
    drive_step('0);
    // R3 R6: forward charging
    drive_step(32'sd50 <<< 16);
    // R4 R10: positive current with strongly negative supply stays forward
    drive_step(-(32'sd100 <<< 16));
    drive_step(32'sd300 <<< 16);
    drive_step(32'sd300 <<< 16);
    // R7: reverse supply drives the reverse pair
    for (int k = 0; k < 6; k++) drive_step(-(32'sd320 <<< 16));
    for (int k = 0; k < 6; k++) drive_step(32'sd200 <<< 16);

    // R8: land current exactly at zero with charged capacitor, then block
    do_reset();
    drive_step(32'sd50 <<< 16);
    x = -(96'(m_cur) <<< FRAC) + 96'(KR) * 96'(m_cur);
    drive_step(W'(x / 96'(KL)));
    check("R8 current landed at zero", 64'(m_cur), 64'd0);
    v_before = m_vdc;
    drive_step('0);
    check("R8 dc decays in blocking mode", 64'(m_vdc < v_before && m_vdc > 0), 64'd1);

    // R2: idle cycles leave state untouched
    repeat (2) @(negedge clk);
    hold_i = i_out;
    hold_v = vdc_out;
    repeat (5) @(negedge clk);
    check("R2 hold current", 64'(i_out), 64'(hold_i));
    check("R2 hold dc voltage", 64'(vdc_out), 64'(hold_v));
    check("R2 no valid when idle", 64'(valid_out), 64'd0);

    // R9: full-scale supply drives current into clipping
    do_reset();
    for (int k = 0; k < 10; k++) drive_step(SMAX);
    repeat (2) @(negedge clk);
    check("R9 clipping reached", 64'(sat_seen), 64'd1);
    check("R9 current pinned positive", 64'(i_out > 0), 64'd1);
    check("R2 scoreboard drained", 64'(sb_q.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule